// File: doc/BRIEF.md
# Boot ROM Checksum Access Gate

This block sits beside a system bus and passively watches every data word fetched from the boot ROM. From reset it keeps a running 32-bit sum of those words and holds a downstream device register window closed, so any read through the window returns all ones. Software tells the block which ROM address closes the checked region by writing an end-address register. When a ROM fetch hits that address, the sum, including that last word, is compared with a built-in constant.

A match opens the window (pass state). A mismatch drops the block into a fail state that only reset clears. From the pass state, software can re-arm the check by writing the end-address register again. That clears the sum and closes the window until a new region has been fetched and matched. A small register port gives a read-only status code and the end-address register, which always reads back a fixed pattern.

Top module: `rom_sum_gate`

## Requirements
- R1: After reset the status code is 0 (checking) and every read through the device window returns 0xFFFFFFFF.
- R2: A register read at byte offset 0xEC returns the status code in bits [1:0] with zeros above: 0 = checking, 2 = failed, 3 = passed. Writes to 0xEC have no effect, and reads at unmapped offsets return 0.
- R3: A register read at offset 0xE4 (end-address register) always returns 0x000000FF, whatever was written.
- R4: In state 0, each valid ROM fetch adds its data to the sum. When the fetch address equals the end address and the sum including that word equals EXPECTED_SUM, the status becomes 3 in the cycle after the fetch.
- R5: In state 0, a fetch at the end address whose inclusive sum differs from EXPECTED_SUM makes the status 2 in the cycle after the fetch.
- R6: The device window passes device read data unchanged only in state 3. In states 0 and 2 it returns 0xFFFFFFFF.
- R7: A write to 0xE4 in state 3 returns the block to state 0, clears the sum to zero and loads the new end address.
- R8: In state 2 summing stops, writes to 0xE4 have no effect, and fetches whose data would match do not leave state 2. Only reset leaves state 2.
- R9: The end address resets to END_ADDR_RST. In state 0, a fetch at any other address only adds to the sum, and a write to 0xE4 replaces the end address without clearing the sum.
- R10: The sum wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rom_rd_vld_i | input | 1 | A ROM data fetch completes this cycle |
| rom_rd_addr_i | input | ADDR_W | Address of the snooped ROM fetch |
| rom_rd_data_i | input | DATA_W | Data of the snooped ROM fetch |
| reg_vld_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Register access is a write |
| reg_addr_i | input | REG_AW | Register byte offset |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational on offset) |
| dev_rdata_i | input | DATA_W | Read data from the device window |
| dev_rdata_o | output | DATA_W | Gated device read data |
| dev_open_o | output | 1 | Device window is accessible |

## Verification
The main function is driven with fetch streams of different lengths, base values and increments. Some sum exactly to the constant, some miss it by a small step, one reaches it only through 32-bit wraparound, and one is a single word at the end address. These separate correct inclusive summing from off-by-one and truncation faults. Directed sequences then check that fetches off the end address never end the check, that re-arming from pass really clears the sum (a stale sum would fail), that a matching stream cannot revive a failed block, and that the status register ignores writes.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  typedef enum logic [1:0] {
    ST_CHECK = 2'd0,
    ST_FAIL  = 2'd2,
    ST_PASS  = 2'd3
  } gate_state_e;
endpackage

// File: rtl/rsg_accum.sv
module rsg_accum #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] sum_next_o
);
  logic [DATA_W-1:0] sum_q;

  // inclusive sum: value after adding the word on the bus now
  assign sum_next_o = sum_q + data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sum_q <= '0;
    else if (clr_i) sum_q <= '0;
    else if (add_i) sum_q <= sum_next_o;
  end
endmodule

// File: rtl/rsg_ctrl.sv
module rsg_ctrl
  import rsg_pkg::*;
#(
  parameter int                ADDR_W       = 21,
  parameter int                DATA_W       = 32,
  parameter logic [DATA_W-1:0] EXPECTED_SUM = 32'h0,
  parameter logic [DATA_W-1:0] END_ADDR_RST = 32'h001F_FFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rom_vld_i,
  input  logic [ADDR_W-1:0] rom_addr_i,
  input  logic [DATA_W-1:0] sum_next_i,
  input  logic              eaddr_wr_i,
  input  logic [DATA_W-1:0] eaddr_wdata_i,
  output gate_state_e       state_o,
  output logic              add_o,
  output logic              clr_o
);
  localparam int PAD_W = DATA_W - ADDR_W;

  gate_state_e       st_q, st_d;
  logic [DATA_W-1:0] end_q;
  logic              hit;

  assign hit   = (st_q == ST_CHECK) && rom_vld_i
                 && ({{PAD_W{1'b0}}, rom_addr_i} == end_q);
  assign add_o = (st_q == ST_CHECK) && rom_vld_i;
  assign clr_o = (st_q == ST_PASS) && eaddr_wr_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_CHECK: if (hit) st_d = (sum_next_i == EXPECTED_SUM) ? ST_PASS : ST_FAIL;
      ST_PASS:  if (eaddr_wr_i) st_d = ST_CHECK;
      default:  st_d = ST_FAIL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_CHECK;
      end_q <= END_ADDR_RST;
    end else begin
      st_q <= st_d;
      if (eaddr_wr_i && st_q != ST_FAIL) end_q <= eaddr_wdata_i;
    end
  end

  assign state_o = st_q;

  // R4
  pass_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && sum_next_i == EXPECTED_SUM) |=> st_q == ST_PASS);
  // R5
  fail_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && sum_next_i != EXPECTED_SUM) |=> st_q == ST_FAIL);
  // R7
  rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PASS && eaddr_wr_i) |=> st_q == ST_CHECK);
  // R8
  fail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_FAIL |=> (st_q == ST_FAIL && $stable(end_q)));
endmodule

// File: rtl/rsg_regs.sv
module rsg_regs
  import rsg_pkg::*;
#(
  parameter int              DATA_W    = 32,
  parameter int              REG_AW    = 8,
  parameter logic [REG_AW-1:0] EADR_OFS = 8'hE4,
  parameter logic [REG_AW-1:0] STAT_OFS = 8'hEC
) (
  input  logic              reg_vld_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  gate_state_e       state_i,
  output logic              eaddr_wr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [DATA_W-1:0] EADR_RD = DATA_W'(8'hFF);

  assign eaddr_wr_o = reg_vld_i && reg_we_i && (reg_addr_i == EADR_OFS);

  always_comb begin
    rdata_o = '0;
    if (reg_addr_i == EADR_OFS)      rdata_o = EADR_RD;
    else if (reg_addr_i == STAT_OFS) rdata_o = DATA_W'(state_i);
  end
endmodule

// File: rtl/rsg_window.sv
module rsg_window #(
  parameter int DATA_W = 32
) (
  input  logic              open_i,
  input  logic [DATA_W-1:0] dev_rdata_i,
  output logic [DATA_W-1:0] dev_rdata_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign dev_rdata_o[b] = dev_rdata_i[b] | ~open_i;
  end
endmodule

// File: rtl/rom_sum_gate.sv
module rom_sum_gate
  import rsg_pkg::*;
#(
  parameter int                ADDR_W       = 21,
  parameter int                DATA_W       = 32,
  parameter int                REG_AW       = 8,
  parameter logic [DATA_W-1:0] EXPECTED_SUM = 32'h5A5A_1234,
  parameter logic [DATA_W-1:0] END_ADDR_RST = 32'h001F_FFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rom_rd_vld_i,
  input  logic [ADDR_W-1:0] rom_rd_addr_i,
  input  logic [DATA_W-1:0] rom_rd_data_i,
  input  logic              reg_vld_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [DATA_W-1:0] dev_rdata_i,
  output logic [DATA_W-1:0] dev_rdata_o,
  output logic              dev_open_o
);
  gate_state_e       state;
  logic              add, clr, eaddr_wr;
  logic [DATA_W-1:0] sum_next;

  rsg_accum #(.DATA_W(DATA_W)) u_accum (
    .clk_i, .rst_ni,
    .clr_i(clr), .add_i(add), .data_i(rom_rd_data_i),
    .sum_next_o(sum_next)
  );

  rsg_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .EXPECTED_SUM(EXPECTED_SUM), .END_ADDR_RST(END_ADDR_RST)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .rom_vld_i(rom_rd_vld_i), .rom_addr_i(rom_rd_addr_i),
    .sum_next_i(sum_next),
    .eaddr_wr_i(eaddr_wr), .eaddr_wdata_i(reg_wdata_i),
    .state_o(state), .add_o(add), .clr_o(clr)
  );

  rsg_regs #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_regs (
    .reg_vld_i, .reg_we_i, .reg_addr_i,
    .state_i(state), .eaddr_wr_o(eaddr_wr), .rdata_o(reg_rdata_o)
  );

  assign dev_open_o = (state == ST_PASS);

  rsg_window #(.DATA_W(DATA_W)) u_window (
    .open_i(dev_open_o), .dev_rdata_i, .dev_rdata_o
  );

  // R6
  window_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_PASS) |-> dev_rdata_o == '1);
  // R6
  window_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_PASS) |-> dev_rdata_o == dev_rdata_i);
  // R2
  state_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state != 2'd1);
endmodule

// File: tb/sim_rom_sum_gate.sv
module sim_rom_sum_gate;
  localparam int          ADDR_W = 21;
  localparam logic [31:0] EXP    = 32'd100;
  localparam logic [31:0] DEVPAT = 32'h1357_9BDF;
  localparam logic [7:0]  OFS_E  = 8'hE4;
  localparam logic [7:0]  OFS_S  = 8'hEC;

  // {count, base, step, expected status}
  localparam int NV = 6;
  localparam logic [79:0] VEC [NV] = '{
    {8'd4, 32'd10,         32'd10,   8'd3},
    {8'd4, 32'd10,         32'd11,   8'd2},
    {8'd2, 32'hFFFF_FFF0,  32'h84,   8'd3},
    {8'd1, 32'd100,        32'd0,    8'd3},
    {8'd5, 32'd20,         32'd0,    8'd3},
    {8'd3, 32'd0,          32'd0,    8'd2}
  };

  logic              clk = 0, rst_ni = 0;
  logic              rom_rd_vld_i = 0;
  logic [ADDR_W-1:0] rom_rd_addr_i = '0;
  logic [31:0]       rom_rd_data_i = '0;
  logic              reg_vld_i = 0, reg_we_i = 0;
  logic [7:0]        reg_addr_i = '0;
  logic [31:0]       reg_wdata_i = '0, reg_rdata_o;
  logic [31:0]       dev_rdata_i = DEVPAT, dev_rdata_o;
  logic              dev_open_o;
  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  rom_sum_gate #(.ADDR_W(ADDR_W), .EXPECTED_SUM(EXP)) u0 (
    .clk_i(clk), .rst_ni, .rom_rd_vld_i, .rom_rd_addr_i, .rom_rd_data_i,
    .reg_vld_i, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .dev_rdata_i, .dev_rdata_o, .dev_open_o
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%08h exp=%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 0;
    @(negedge clk); @(negedge clk); rst_ni = 1;
    @(negedge clk);
  endtask

  task automatic rom_rd(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    rom_rd_vld_i = 1; rom_rd_addr_i = a; rom_rd_data_i = d;
    @(negedge clk);
    rom_rd_vld_i = 0;
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_vld_i = 1; reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_vld_i = 0; reg_we_i = 0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr_i = a; #1; d = reg_rdata_o;
  endtask

  task automatic status_is(input string req, input logic [31:0] exp);
    logic [31:0] d;
    reg_rd(OFS_S, d);
    chk(req, d, exp);
    chk(req, dev_rdata_o, (exp == 32'd3) ? DEVPAT : 32'hFFFF_FFFF);
  endtask

  initial begin
    logic [31:0] d;
    do_reset();
    // R1 reset state, R2 status readback, R3 end-address readback
    status_is("R1", 0);
    reg_rd(OFS_E, d); chk("R3", d, 32'h0000_00FF);
    reg_rd(8'h10, d); chk("R2 unmapped", d, 0);
    reg_wr(OFS_S, 32'h3);
    status_is("R2 write ignored", 0);

    // table: R4 pass, R5 fail, R10 wrap
    for (int v = 0; v < NV; v++) begin
      logic [7:0]  n    = VEC[v][79:72];
      logic [31:0] base = VEC[v][71:40];
      logic [31:0] step = VEC[v][39:8];
      logic [31:0] exps = {24'd0, VEC[v][7:0]};
      do_reset();
      reg_wr(OFS_E, 32'h100 + n - 1);
      for (int i = 0; i < n; i++) begin
        rom_rd(ADDR_W'(32'h100 + i), base + step * i);
        if (i < n - 1) status_is("R4 before end", 0);
      end
      status_is(exps == 3 ? "R4/R10 table pass" : "R5 table fail", exps);
    end

    // R9 default end address, non-end fetch only sums
    do_reset();
    rom_rd(21'h5, 32'd40);
    status_is("R9 non-end", 0);
    rom_rd(21'h1F_FFFF, 32'd60);
    status_is("R9 default end", 3);
    reg_rd(OFS_E, d); chk("R3 after pass", d, 32'h0000_00FF);

    // R7 re-arm clears sum
    reg_wr(OFS_E, 32'h10);
    status_is("R7 rearm", 0);
    rom_rd(21'h0F, 32'd60);
    rom_rd(21'h10, 32'd40);
    status_is("R7 cleared sum", 3);

    // R9 rewrite in state 0 moves end, keeps sum
    do_reset();
    reg_wr(OFS_E, 32'h40);
    reg_wr(OFS_E, 32'h50);
    rom_rd(21'h40, 32'd50);
    status_is("R9 old end ignored", 0);
    rom_rd(21'h50, 32'd50);
    status_is("R9 moved end", 3);

    // R8 fail is sticky
    do_reset();
    reg_wr(OFS_E, 32'h20);
    rom_rd(21'h20, 32'd1);
    status_is("R5 single", 2);
    reg_wr(OFS_E, 32'h30);
    status_is("R8 write ignored", 2);
    rom_rd(21'h30, 32'd100);
    rom_rd(21'h20, 32'd99);
    status_is("R8 no summing", 2);
    do_reset();
    status_is("R8 reset exits", 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule